// File: doc/BRIEF.md
# Link Bring-up and Speed-Change Sequencer

This block walks a serial link through a cautious start. It first caps the allowed link speed at the first generation and only then enables training. After the link reports up, it raises the speed cap to the second generation if it is configured for that. It then issues a directed speed-change request, polls for that change to finish with a bounded number of retries, and checks a second time that the link is up and no longer training. When all of this succeeds it reports the negotiated speed.

Any failure runs a receiver reset in the PHY before failure is reported. A link-up wait that times out, or a speed change that never completes, is a failure. The receiver reset is a read-modify-write that sets the receive-data-enable and receive-PLL-enable override bits of a PHY register. The bits are held set for a programmable time and then cleared by a second read-modify-write. The PHY register accesses leave through a valid/ready request port with a separate response strobe.

The request port follows valid/ready rules. Once the block raises `phy_req_valid_o`, it keeps the valid and every request field steady until it samples `phy_req_ready_i` high on a clock edge. The response side has no back-pressure. The block always takes a `phy_rsp_valid_i` strobe, which must come one or more cycles after the handshake and lasts a single cycle. Every request, whether read or write, expects exactly one response.

Top module: `lnk_bringup_seq`

## Requirements
- R1: After reset, the speed cap is 1, training enable is low, the speed-change request is low, both result pulses are low, the reported speed is 0, and no PHY request is valid.
- R2: A start pulse while idle sets the speed cap to 1, drops training enable and clears the reported speed on the next edge. Training enable rises one edge after that, and the cap is already 1 when it does.
- R3: The link counts as up only when the link-up flag is 1 and the in-training flag is 0. While the in-training flag is 1, the sequence does not advance past either link wait.
- R4: After the first link-up, the speed cap becomes 2 only when the configured generation equals exactly 2. Any other configured value leaves the cap at 1.
- R5: One edge after the first link-up is seen, the speed-change request is a single-cycle pulse. The pending flag is polled every SPD_GAP_CYC+1 cycles, with the first poll SPD_GAP_CYC+1 edges after the pulse. A poll that finds the flag clear ends the wait.
- R6: If the pending flag is still set at poll number SPD_TRIES, the speed change fails. A clear flag seen at that last poll still counts as success.
- R7: After the speed change, the link-up condition is required again. Success gives a one-cycle done pulse, and the reported speed takes the 4-bit speed status on the same edge.
- R8: If a link wait sees no link-up within LINK_TO_CYC cycles, it fails. The first PHY request becomes valid LINK_TO_CYC+2 cycles after training enable rises.
- R9: On failure, the block reads PHY register 0x1005 and writes back the value with bits 5 and 3 set (OR 0x0028). It waits at least RX_HOLD_CYC cycles, reads the register again and writes back the value with bits 5 and 3 cleared. Only then does it give a one-cycle fail pulse.
- R10: A PHY request keeps its valid, direction, address and data stable until it is accepted.
- R11: Done and fail are never high together and each lasts one cycle. The reported speed changes only on a done pulse or a start, and a failure leaves it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a bring-up sequence (taken only when idle) |
| gen_cfg_i | input | 4 | Configured maximum generation |
| link_up_i | input | 1 | Link-up flag (debug status bit 4) |
| in_train_i | input | 1 | Link-in-training flag (debug status bit 29) |
| spd_pend_i | input | 1 | Speed-change-pending readback (control bit 17) |
| lnk_speed_i | input | 4 | Negotiated speed field (link status bits 19:16) |
| max_speed_o | output | 4 | Maximum-speed cap driven to the link controller |
| train_en_o | output | 1 | Training enable |
| spd_chg_o | output | 1 | Directed speed-change request pulse (sets bit 17) |
| done_o | output | 1 | Success pulse |
| fail_o | output | 1 | Failure pulse (after the receiver reset) |
| speed_o | output | 4 | Reported speed, valid from done until the next start |
| phy_req_valid_o | output | 1 | PHY register request valid |
| phy_req_ready_i | input | 1 | PHY register request ready |
| phy_req_write_o | output | 1 | 1 = write, 0 = read |
| phy_req_addr_o | output | 16 | PHY register address |
| phy_req_wdata_o | output | 16 | PHY write data |
| phy_rsp_valid_i | input | 1 | Response strobe (read data or write acknowledge) |
| phy_rsp_rdata_i | input | 16 | Read data |

## Verification
After start, the speed cap and reported speed settle one edge later and training enable one edge after that. The bench samples each of these at the falling edge that follows. Poll timing is measured from the falling edge where the request pulse is first seen, counting rising edges. The pending flag is released either just before edge SPD_TRIES*(SPD_GAP_CYC+1) or just after it, so the two runs land on opposite sides of the last poll. The link-timeout latency is checked as an exact count of LINK_TO_CYC+2 falling edges from training enable to the first PHY request. The hold time is measured between the handshakes of the two PHY accesses. The done and fail pulses are awaited with a bounded loop and checked in the falling-edge window where they appear.

// File: rtl/lbs_pkg.sv
`timescale 1ns/1ps
package lbs_pkg;
  localparam logic [3:0] SPD_GEN1 = 4'd1;
  localparam logic [3:0] SPD_GEN2 = 4'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_ARM, S_WLINK1, S_REQ, S_SPDWAIT, S_WLINK2, S_RXGO, S_RXWAIT
  } seq_st_e;

  typedef enum logic [2:0] {
    R_IDLE, R_RD, R_RDW, R_WR, R_WRW, R_HOLD
  } rr_st_e;
endpackage

// File: rtl/lbs_timer.sv
`timescale 1ns/1ps
module lbs_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && zero) |=> zero); // R5
endmodule

// File: rtl/lbs_rxrst.sv
`timescale 1ns/1ps
module lbs_rxrst import lbs_pkg::*; #(
  parameter int          AW       = 16,
  parameter int          DW       = 16,
  parameter logic [AW-1:0] REG_ADDR = 16'h1005,
  parameter logic [DW-1:0] OVR_MASK = 16'h0028,
  parameter int          HOLD_CYC = 250000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  output logic          done,
  output logic          req_valid,
  input  logic          req_ready,
  output logic          req_write,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_rdata
);
  localparam int HW = $clog2(HOLD_CYC + 1);

  rr_st_e        st;
  logic          clr_pass;
  logic [DW-1:0] wval;
  logic          hold_load;
  logic          hold_zero;

  assign hold_load = (st == R_WRW) && rsp_valid && !clr_pass;

  lbs_timer #(.W(HW)) u_hold (
    .clk  (clk),
    .rst_n(rst_n),
    .load (hold_load),
    .val  (HW'(HOLD_CYC)),
    .zero (hold_zero)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= R_IDLE;
      clr_pass <= 1'b0;
      wval     <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        R_IDLE: if (go) begin
          clr_pass <= 1'b0;
          st       <= R_RD;
        end
        R_RD:   if (req_ready) st <= R_RDW;
        R_RDW:  if (rsp_valid) begin
          wval <= clr_pass ? (rsp_rdata & ~OVR_MASK) : (rsp_rdata | OVR_MASK);
          st   <= R_WR;
        end
        R_WR:   if (req_ready) st <= R_WRW;
        R_WRW:  if (rsp_valid) begin
          if (clr_pass) begin
            done <= 1'b1;
            st   <= R_IDLE;
          end else begin
            st <= R_HOLD;
          end
        end
        R_HOLD: if (hold_zero) begin
          clr_pass <= 1'b1;
          st       <= R_RD;
        end
        default: st <= R_IDLE;
      endcase
    end
  end

  assign req_valid = (st == R_RD) || (st == R_WR);
  assign req_write = (st == R_WR);
  assign req_addr  = REG_ADDR;
  assign req_wdata = (st == R_WR) ? wval : '0;

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_write) &&
                                   $stable(req_addr) && $stable(req_wdata))); // R10
  AST_REQ_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr == REG_ADDR)); // R9
  AST_WR_SETS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !clr_pass) |-> ((req_wdata & OVR_MASK) == OVR_MASK)); // R9
  AST_WR_CLRS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && clr_pass) |-> ((req_wdata & OVR_MASK) == '0)); // R9
endmodule

// File: rtl/lnk_bringup_seq.sv
`timescale 1ns/1ps
module lnk_bringup_seq import lbs_pkg::*; #(
  parameter int          LINK_TO_CYC  = 20000,
  parameter int          SPD_GAP_CYC  = 10000,
  parameter int          SPD_TRIES    = 200,
  parameter int          RX_HOLD_CYC  = 250000,
  parameter int          PHY_AW       = 16,
  parameter int          PHY_DW       = 16,
  parameter logic [15:0] PHY_RX_REG   = 16'h1005,
  parameter logic [15:0] RX_OVR_MASK  = 16'h0028
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [3:0]        gen_cfg_i,
  input  logic              link_up_i,
  input  logic              in_train_i,
  input  logic              spd_pend_i,
  input  logic [3:0]        lnk_speed_i,
  output logic [3:0]        max_speed_o,
  output logic              train_en_o,
  output logic              spd_chg_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [3:0]        speed_o,
  output logic              phy_req_valid_o,
  input  logic              phy_req_ready_i,
  output logic              phy_req_write_o,
  output logic [PHY_AW-1:0] phy_req_addr_o,
  output logic [PHY_DW-1:0] phy_req_wdata_o,
  input  logic              phy_rsp_valid_i,
  input  logic [PHY_DW-1:0] phy_rsp_rdata_i
);
  localparam int TMAX = (LINK_TO_CYC > SPD_GAP_CYC) ? LINK_TO_CYC : SPD_GAP_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int NW   = $clog2(SPD_TRIES + 1);
  localparam logic [NW-1:0] LAST_TRY = NW'(SPD_TRIES - 1);

  seq_st_e       st;
  logic [NW-1:0] tries;
  logic          link_ok;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_zero;
  logic          rr_go;
  logic          rr_done;
  logic          poll_clear;
  logic          poll_retry;

  assign link_ok    = link_up_i && !in_train_i;
  assign poll_clear = (st == S_SPDWAIT) && tmr_zero && !spd_pend_i;
  assign poll_retry = (st == S_SPDWAIT) && tmr_zero && spd_pend_i && (tries != LAST_TRY);

  always_comb begin
    tmr_load = (st == S_ARM) || (st == S_REQ) || poll_clear || poll_retry;
    tmr_val  = ((st == S_ARM) || poll_clear) ? TW'(LINK_TO_CYC) : TW'(SPD_GAP_CYC);
  end

  lbs_timer #(.W(TW)) u_wait_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .load (tmr_load),
    .val  (tmr_val),
    .zero (tmr_zero)
  );

  assign rr_go = (st == S_RXGO);

  lbs_rxrst #(
    .AW      (PHY_AW),
    .DW      (PHY_DW),
    .REG_ADDR(PHY_AW'(PHY_RX_REG)),
    .OVR_MASK(PHY_DW'(RX_OVR_MASK)),
    .HOLD_CYC(RX_HOLD_CYC)
  ) u_rxrst (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (rr_go),
    .done     (rr_done),
    .req_valid(phy_req_valid_o),
    .req_ready(phy_req_ready_i),
    .req_write(phy_req_write_o),
    .req_addr (phy_req_addr_o),
    .req_wdata(phy_req_wdata_o),
    .rsp_valid(phy_rsp_valid_i),
    .rsp_rdata(phy_rsp_rdata_i)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      max_speed_o <= SPD_GEN1;
      train_en_o  <= 1'b0;
      spd_chg_o   <= 1'b0;
      done_o      <= 1'b0;
      fail_o      <= 1'b0;
      speed_o     <= '0;
      tries       <= '0;
    end else begin
      done_o    <= 1'b0;
      fail_o    <= 1'b0;
      spd_chg_o <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          max_speed_o <= SPD_GEN1;
          train_en_o  <= 1'b0;
          speed_o     <= '0;
          st          <= S_ARM;
        end
        S_ARM: begin
          train_en_o <= 1'b1;
          st         <= S_WLINK1;
        end
        S_WLINK1: begin
          if (link_ok) begin
            if (gen_cfg_i == SPD_GEN2) max_speed_o <= SPD_GEN2;
            st <= S_REQ;
          end else if (tmr_zero) begin
            st <= S_RXGO;
          end
        end
        S_REQ: begin
          spd_chg_o <= 1'b1;
          tries     <= '0;
          st        <= S_SPDWAIT;
        end
        S_SPDWAIT: if (tmr_zero) begin
          if (!spd_pend_i)            st <= S_WLINK2;
          else if (tries == LAST_TRY) st <= S_RXGO;
          else                        tries <= tries + 1'b1;
        end
        S_WLINK2: begin
          if (link_ok) begin
            done_o  <= 1'b1;
            speed_o <= lnk_speed_i;
            st      <= S_IDLE;
          end else if (tmr_zero) begin
            st <= S_RXGO;
          end
        end
        S_RXGO: st <= S_RXWAIT;
        S_RXWAIT: if (rr_done) begin
          fail_o <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_TRAIN_AT_GEN1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(train_en_o) |-> (max_speed_o == SPD_GEN1)); // R2
  AST_SPDREQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    spd_chg_o |=> !spd_chg_o); // R5
  AST_CAP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (max_speed_o == SPD_GEN1) || (max_speed_o == SPD_GEN2)); // R4
  AST_UPGRADE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(max_speed_o[1]) |-> ($past(gen_cfg_i) == SPD_GEN2)); // R4
  AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && fail_o)); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R11
  AST_FAIL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |=> !fail_o); // R11
  AST_SPEED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(speed_o) |-> (done_o || (speed_o == '0))); // R11
  AST_FAIL_AFTER_RXRST: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |-> !phy_req_valid_o); // R9
endmodule

// File: tb/lnk_bringup_seq_bench.sv
`timescale 1ns/1ps
module lnk_bringup_seq_bench;
  localparam int LTO = 40;
  localparam int GAP = 4;
  localparam int TRY = 5;
  localparam int HLD = 20;
  localparam int LAST_POLL = TRY * (GAP + 1);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  gen_cfg_i = 4'd1;
  logic        link_up_i = 1'b0;
  logic        in_train_i = 1'b0;
  logic        spd_pend_i = 1'b0;
  logic [3:0]  lnk_speed_i = 4'd0;
  logic [3:0]  max_speed_o;
  logic        train_en_o, spd_chg_o, done_o, fail_o;
  logic [3:0]  speed_o;
  logic        phy_req_valid_o, phy_req_write_o;
  logic        phy_req_ready_i = 1'b0;
  logic [15:0] phy_req_addr_o, phy_req_wdata_o;
  logic        phy_rsp_valid_i = 1'b0;
  logic [15:0] phy_rsp_rdata_i = 16'h0;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lnk_bringup_seq #(
    .LINK_TO_CYC(LTO), .SPD_GAP_CYC(GAP), .SPD_TRIES(TRY), .RX_HOLD_CYC(HLD)
  ) u_lnk_bringup_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .gen_cfg_i(gen_cfg_i),
    .link_up_i(link_up_i), .in_train_i(in_train_i), .spd_pend_i(spd_pend_i),
    .lnk_speed_i(lnk_speed_i), .max_speed_o(max_speed_o), .train_en_o(train_en_o),
    .spd_chg_o(spd_chg_o), .done_o(done_o), .fail_o(fail_o), .speed_o(speed_o),
    .phy_req_valid_o(phy_req_valid_o), .phy_req_ready_i(phy_req_ready_i),
    .phy_req_write_o(phy_req_write_o), .phy_req_addr_o(phy_req_addr_o),
    .phy_req_wdata_o(phy_req_wdata_o), .phy_rsp_valid_i(phy_rsp_valid_i),
    .phy_rsp_rdata_i(phy_rsp_rdata_i)
  );

  // PHY register responder: stalls one cycle, accepts, answers two cycles later.
  int          n_acc = 0;
  logic        lg_wr [0:7];
  logic [15:0] lg_addr [0:7];
  logic [15:0] lg_data [0:7];
  int          lg_cyc [0:7];
  logic        l_wr;
  logic [15:0] l_addr, l_data;
  bit          pend_rsp = 0;
  int          stall = 0;
  int          rd_idx = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      phy_req_ready_i = 1'b0; phy_rsp_valid_i = 1'b0; pend_rsp = 0; stall = 0;
    end else if (phy_req_ready_i) begin
      phy_req_ready_i = 1'b0;
      if (n_acc < 8) begin
        lg_wr[n_acc] = l_wr; lg_addr[n_acc] = l_addr;
        lg_data[n_acc] = l_data; lg_cyc[n_acc] = cyc;
      end
      n_acc = n_acc + 1;
      pend_rsp = 1;
    end else if (pend_rsp) begin
      phy_rsp_valid_i = 1'b1;
      phy_rsp_rdata_i = (rd_idx % 2 == 0) ? 16'h1234 : 16'h00FF;
      if (!l_wr) rd_idx = rd_idx + 1;
      pend_rsp = 0;
    end else begin
      phy_rsp_valid_i = 1'b0;
      if (phy_req_valid_o) begin
        if (stall >= 1) begin
          phy_req_ready_i = 1'b1; stall = 0;
          l_wr = phy_req_write_o; l_addr = phy_req_addr_o; l_data = phy_req_wdata_o;
        end else stall = stall + 1;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic wait_req(output bit seen);
    seen = 0;
    for (int i = 0; i < 300 && !seen; i++) begin
      @(negedge clk);
      if (spd_chg_o) seen = 1;
    end
  endtask

  task automatic wait_end(output bit d, output bit f);
    d = 0; f = 0;
    for (int i = 0; i < 3000 && !d && !f; i++) begin
      @(negedge clk);
      d = done_o; f = fail_o;
    end
  endtask

  task automatic t_reset();
    check("R1 cap", int'(max_speed_o), 1);
    check("R1 train", int'(train_en_o), 0);
    check("R1 spdreq", int'(spd_chg_o), 0);
    check("R1 done/fail", int'({done_o, fail_o}), 0);
    check("R1 speed", int'(speed_o), 0);
    check("R1 phyreq", int'(phy_req_valid_o), 0);
  endtask

  // Gen1 configured, link already up: no upgrade, quick success.
  task automatic t_gen1_ok();
    bit seen, d, f;
    gen_cfg_i = 4'd1; link_up_i = 1; in_train_i = 0; lnk_speed_i = 4'd1;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    check("R2 cap after start", int'(max_speed_o), 1);
    check("R2 train low after start", int'(train_en_o), 0);
    check("R2 speed cleared", int'(speed_o), 0);
    @(negedge clk);
    check("R2 train rises", int'(train_en_o), 1);
    wait_req(seen);
    check("R5 request seen", int'(seen), 1);
    check("R4 gen1 keeps cap", int'(max_speed_o), 1);
    spd_pend_i = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); spd_pend_i = 0;
    wait_end(d, f);
    check("R7 done", int'(d), 1);
    check("R7 speed", int'(speed_o), 1);
    @(negedge clk);
    check("R11 done one cycle", int'(done_o), 0);
    repeat (10) @(negedge clk);
    check("R11 speed held", int'(speed_o), 1);
  endtask

  // Gen2: in-training blocks, upgrade, pend cleared right before last poll.
  task automatic t_gen2_ok();
    bit seen, d, f;
    int reqs;
    gen_cfg_i = 4'd2; link_up_i = 0; in_train_i = 0; lnk_speed_i = 4'd2;
    pulse_start();
    check("R11 start clears speed", int'(speed_o), 0);
    repeat (5) @(negedge clk);
    link_up_i = 1; in_train_i = 1;
    reqs = 0;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      if (spd_chg_o) reqs++;
    end
    check("R3 in-training blocks", reqs, 0);
    check("R3 cap unchanged while training", int'(max_speed_o), 1);
    in_train_i = 0;
    wait_req(seen);
    check("R5 request seen", int'(seen), 1);
    check("R4 gen2 raises cap", int'(max_speed_o), 2);
    spd_pend_i = 1;
    repeat (LAST_POLL - 1) @(posedge clk);
    @(negedge clk); spd_pend_i = 0;
    wait_end(d, f);
    check("R6 last poll clear succeeds", int'(d), 1);
    check("R7 speed gen2", int'(speed_o), 2);
  endtask

  task automatic t_gen3();
    bit seen, d, f;
    gen_cfg_i = 4'd3; link_up_i = 1; in_train_i = 0; lnk_speed_i = 4'd1;
    pulse_start();
    wait_req(seen);
    check("R4 gen3 keeps cap", int'(max_speed_o), 1);
    wait_end(d, f);
    check("R7 done gen3", int'(d), 1);
  endtask

  // Pend still set at the last poll: failure with receiver reset.
  task automatic t_spd_fail();
    bit seen, d, f;
    int base;
    gen_cfg_i = 4'd2; link_up_i = 1; in_train_i = 0; lnk_speed_i = 4'd2;
    base = n_acc;
    pulse_start();
    wait_req(seen);
    spd_pend_i = 1;
    repeat (LAST_POLL) @(posedge clk);
    @(negedge clk); spd_pend_i = 0;
    wait_end(d, f);
    check("R6 late clear fails", int'(f), 1);
    check("R6 no done", int'(d), 0);
    check("R11 speed zero after fail", int'(speed_o), 0);
    check("R9 four accesses", n_acc - base, 4);
    if (n_acc - base == 4) begin
      check("R9 rd1 dir", int'(lg_wr[base]), 0);
      check("R9 rd1 addr", int'(lg_addr[base]), 16'h1005);
      check("R9 wr1 dir", int'(lg_wr[base+1]), 1);
      check("R9 wr1 data", int'(lg_data[base+1]), 16'h123C);
      check("R9 rd2 dir", int'(lg_wr[base+2]), 0);
      check("R9 wr2 data", int'(lg_data[base+3]), 16'h00D7);
      check("R9 wr2 addr", int'(lg_addr[base+3]), 16'h1005);
      check("R9 hold long enough",
            int'((lg_cyc[base+2] - lg_cyc[base+1]) >= HLD), 1);
    end
    @(negedge clk);
    check("R11 fail one cycle", int'(fail_o), 0);
  endtask

  // No link at all: timeout latency then receiver reset and fail.
  task automatic t_link_to();
    bit d, f;
    int n;
    gen_cfg_i = 4'd1; link_up_i = 0; in_train_i = 0;
    rd_idx = 0;
    pulse_start();
    @(negedge clk);
    check("R2 train up", int'(train_en_o), 1);
    n = 0;
    while (!phy_req_valid_o && n < 500) begin
      @(negedge clk); n++;
    end
    check("R8 timeout latency", n, LTO + 2);
    wait_end(d, f);
    check("R8 fail on timeout", int'(f), 1);
  endtask

  initial begin
    #1_500_000;
    nerr++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gen1_ok();
    t_gen2_ok();
    t_gen3();
    t_spd_fail();
    t_link_to();
    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule